// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles an equal-compare conditional branch while the branch is still in the decode stage of a five-stage in-order pipeline. It picks each of the two source operands from one of three places: the register file read, the memory-stage result, or the writeback-stage result. It tests the two operands for equality with a bitwise XOR followed by a single wide NOR, so there is no subtractor and no carry chain. In the same cycle it adds the sign-extended immediate to the branch's PC+4 to form the target. Because the branch resolves this early, only the one instruction behind it has entered the pipeline. That instruction is the delay slot, and it always executes.

When an operand cannot be bypassed yet, the unit stops the front end. The fetch PC and the fetch/decode register hold, and a NOP goes into execute. A producer in execute costs one cycle if it is an ALU instruction and two cycles if it is a load. A load that has reached the memory stage costs one more cycle. A build parameter replaces bypassing with a waiting scheme: the branch stalls until every producer of its operands has left writeback, and the operands are then read from the register file.

The unit also owns the fetch PC register. The register holds during a stall, loads the target after a taken branch, and otherwise steps by four.

Top module: `id_branch_unit`

## Requirements
- R1: `br_taken` is 1 only when `id_branch` is 1, `stall_fd` is 0, and the two selected operand values are bit-for-bit equal.
- R2: `br_target` always equals `id_pc4` plus `id_imm` sign-extended to the data width, modulo 2^32.
- R3: In bypass mode, each operand select is encoded 0 for the register file, 1 for the memory-stage value, and 2 for the writeback-stage value. A matching write in memory takes priority over a match in writeback. The selected value is the one compared.
- R4: In bypass mode, a branch operand written by a non-load in execute raises `stall_fd` for exactly one cycle. The branch then resolves from the memory-stage value.
- R5: In bypass mode, a branch operand written by a load raises `stall_fd` while the load is in execute and while it is in memory. This is two cycles for a load directly ahead, and the value then comes from writeback.
- R6: In conservative mode, every select stays 0. `stall_fd` is raised while any execute, memory or writeback write matches a branch operand, which is three cycles for a producer directly ahead.
- R7: Register number 0 never causes a stall and always selects the register file, even when a stage claims to write it.
- R8: `ex_bubble` equals `stall_fd`, and `br_taken` is 0 in any cycle with `stall_fd` set.
- R9: `fetch_pc` resets to RESET_PC. After a stalled cycle it is unchanged, after a taken cycle it equals that cycle's `br_target`, and otherwise it increases by 4.
- R10: With `id_branch` at 0, the unit neither stalls nor reports a taken branch, whatever the stage contents.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_branch | input | 1 | Decode stage holds an equal-compare branch |
| id_rs | input | 5 | First source register number |
| id_rt | input | 5 | Second source register number |
| id_rs_val | input | 32 | Register file value of the first source |
| id_rt_val | input | 32 | Register file value of the second source |
| id_pc4 | input | 32 | Address of the branch plus 4 |
| id_imm | input | 16 | Branch displacement, signed |
| ex_rd | input | 5 | Destination in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination in memory |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_load | input | 1 | Memory instruction is a load |
| mem_val | input | 32 | ALU result held in memory stage |
| wb_rd | input | 5 | Destination in writeback |
| wb_wr | input | 1 | Writeback instruction writes a register |
| wb_val | input | 32 | Value being written back |
| br_taken | output | 1 | Branch resolved as taken this cycle |
| br_target | output | 32 | Branch destination address |
| stall_fd | output | 1 | Hold fetch PC and fetch/decode register |
| ex_bubble | output | 1 | Insert a NOP with write enables cleared into execute |
| fwd_a_sel | output | 2 | Source select for the first operand |
| fwd_b_sel | output | 2 | Source select for the second operand |
| fetch_pc | output | 32 | Current fetch address |

## Verification
The assertions assume that the stage flags describe a plausible pipeline. A stage whose write flag is low has a meaningless destination field. The memory-stage value is ignored whenever the memory instruction is a load. All inputs settle well before each rising edge. The stimulus drives every input one nanosecond after the rising edge. Its directed runs move a single producer through execute, memory and writeback exactly as a stalled pipeline would, with a bubble behind it and the register file updated only after writeback. Its random phase uses only four register numbers, so that matches in several stages at once, and matches on register 0, occur often.

// File: rtl/idbr_pkg.sv
package idbr_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        HZ_NONE   = 3'd0,
        HZ_X_ALU  = 3'd1,
        HZ_X_LOAD = 3'd2,
        HZ_M_LOAD = 3'd3,
        HZ_M_PEND = 3'd4,
        HZ_W_PEND = 3'd5
    } hz_e;

endpackage

// File: rtl/idbr_operand.sv
module idbr_operand
    import idbr_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int RW           = 5,
    parameter bit CONSERVATIVE = 1'b0
) (
    input  logic            br_valid,
    input  logic [RW-1:0]   src,
    input  logic [XLEN-1:0] rf_val,
    input  logic [RW-1:0]   ex_rd,
    input  logic            ex_wr,
    input  logic            ex_load,
    input  logic [RW-1:0]   mem_rd,
    input  logic            mem_wr,
    input  logic            mem_load,
    input  logic [XLEN-1:0] mem_val,
    input  logic [RW-1:0]   wb_rd,
    input  logic            wb_wr,
    input  logic [XLEN-1:0] wb_val,
    output src_e            sel,
    output logic [XLEN-1:0] val,
    output logic            hold
);

    logic live;
    logic hit_x;
    logic hit_m;
    logic hit_w;
    hz_e  kind;

    // register 0 is hard-wired and never tracked
    assign live  = br_valid && (src != '0);
    assign hit_x = live && ex_wr  && (ex_rd  == src);
    assign hit_m = live && mem_wr && (mem_rd == src);
    assign hit_w = live && wb_wr  && (wb_rd  == src);

    generate
        if (CONSERVATIVE) begin : g_wait
            // wait for every producer to retire, read the register file
            always_comb begin
                kind = HZ_NONE;
                if (hit_x)      kind = ex_load ? HZ_X_LOAD : HZ_X_ALU;
                else if (hit_m) kind = HZ_M_PEND;
                else if (hit_w) kind = HZ_W_PEND;
            end
            assign sel = SRC_RF;
        end else begin : g_fwd
            always_comb begin
                kind = HZ_NONE;
                if (hit_x)                 kind = ex_load ? HZ_X_LOAD : HZ_X_ALU;
                else if (hit_m && mem_load) kind = HZ_M_LOAD;
            end
            // younger producer wins
            always_comb begin
                if (hit_m)      sel = SRC_MEM;
                else if (hit_w) sel = SRC_WB;
                else            sel = SRC_RF;
            end
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SRC_MEM: val = mem_val;
            SRC_WB:  val = wb_val;
            default: val = rf_val;
        endcase
    end

    assign hold = (kind != HZ_NONE);

endmodule

// File: rtl/idbr_compare.sv
module idbr_compare #(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] pc4,
    input  logic [IMMW-1:0] imm,
    output logic            equal,
    output logic [XLEN-1:0] target
);

    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] diff_bits;
    logic [XLEN-1:0] imm_sx;

    // equality without a carry chain: any differing bit clears the NOR
    assign diff_bits = op_a ^ op_b;
    assign equal     = ~|diff_bits;

    assign imm_sx = {{EXTW{imm[IMMW-1]}}, imm};
    assign target = pc4 + imm_sx;

endmodule

// File: rtl/idbr_pc.sv
module idbr_pc #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= RESET_PC;
        end else if (!hold) begin
            pc <= redirect ? target : pc + STEP;
        end
    end

endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit
    import idbr_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              RW           = 5,
    parameter int              IMMW         = 16,
    parameter bit              CONSERVATIVE = 1'b0,
    parameter logic [XLEN-1:0] RESET_PC     = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_branch,
    input  logic [RW-1:0]   id_rs,
    input  logic [RW-1:0]   id_rt,
    input  logic [XLEN-1:0] id_rs_val,
    input  logic [XLEN-1:0] id_rt_val,
    input  logic [XLEN-1:0] id_pc4,
    input  logic [IMMW-1:0] id_imm,
    input  logic [RW-1:0]   ex_rd,
    input  logic            ex_wr,
    input  logic            ex_load,
    input  logic [RW-1:0]   mem_rd,
    input  logic            mem_wr,
    input  logic            mem_load,
    input  logic [XLEN-1:0] mem_val,
    input  logic [RW-1:0]   wb_rd,
    input  logic            wb_wr,
    input  logic [XLEN-1:0] wb_val,
    output logic            br_taken,
    output logic [XLEN-1:0] br_target,
    output logic            stall_fd,
    output logic            ex_bubble,
    output logic [1:0]      fwd_a_sel,
    output logic [1:0]      fwd_b_sel,
    output logic [XLEN-1:0] fetch_pc
);

    localparam int NOPS = 2;

    logic [NOPS-1:0][RW-1:0]   op_src;
    logic [NOPS-1:0][XLEN-1:0] op_rf;
    logic [NOPS-1:0][XLEN-1:0] op_val;
    src_e                      op_sel [NOPS];
    logic [NOPS-1:0]           op_hold;
    logic                      ops_equal;

    assign op_src[0] = id_rs;
    assign op_src[1] = id_rt;
    assign op_rf[0]  = id_rs_val;
    assign op_rf[1]  = id_rt_val;

    generate
        for (genvar i = 0; i < NOPS; i++) begin : g_op
            idbr_operand #(
                .XLEN         (XLEN),
                .RW           (RW),
                .CONSERVATIVE (CONSERVATIVE)
            ) u_op (
                .br_valid (id_branch),
                .src      (op_src[i]),
                .rf_val   (op_rf[i]),
                .ex_rd    (ex_rd),
                .ex_wr    (ex_wr),
                .ex_load  (ex_load),
                .mem_rd   (mem_rd),
                .mem_wr   (mem_wr),
                .mem_load (mem_load),
                .mem_val  (mem_val),
                .wb_rd    (wb_rd),
                .wb_wr    (wb_wr),
                .wb_val   (wb_val),
                .sel      (op_sel[i]),
                .val      (op_val[i]),
                .hold     (op_hold[i])
            );
        end
    endgenerate

    idbr_compare #(
        .XLEN (XLEN),
        .IMMW (IMMW)
    ) u_cmp (
        .op_a   (op_val[0]),
        .op_b   (op_val[1]),
        .pc4    (id_pc4),
        .imm    (id_imm),
        .equal  (ops_equal),
        .target (br_target)
    );

    assign stall_fd  = |op_hold;
    assign ex_bubble = stall_fd;
    assign br_taken  = id_branch && !stall_fd && ops_equal;
    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    idbr_pc #(
        .XLEN     (XLEN),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stall_fd),
        .redirect (br_taken),
        .target   (br_target),
        .pc       (fetch_pc)
    );

endmodule

// File: rtl/idbr_chk.sv
module idbr_chk #(
    parameter int  XLEN         = 32,
    parameter int  RW           = 5,
    parameter bit  CONSERVATIVE = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_branch,
    input logic [RW-1:0]   id_rs,
    input logic [RW-1:0]   ex_rd,
    input logic            ex_wr,
    input logic [RW-1:0]   mem_rd,
    input logic            mem_wr,
    input logic            mem_load,
    input logic [RW-1:0]   wb_rd,
    input logic            wb_wr,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic            stall_fd,
    input logic [1:0]      fwd_a_sel,
    input logic [XLEN-1:0] fetch_pc
);

    logic rs_live;
    assign rs_live = id_branch && (id_rs != '0);

    assert_stall_kills_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fd |-> !br_taken);

    assert_pc_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fd |=> fetch_pc == $past(fetch_pc));

    assert_pc_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> fetch_pc == $past(br_target));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !id_branch |-> (!stall_fd && !br_taken));

    assert_ex_producer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_live && ex_wr && ex_rd == id_rs) |-> stall_fd);

    assert_load_in_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_live && mem_wr && mem_load && mem_rd == id_rs) |-> stall_fd);

    assert_reg0_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (fwd_a_sel == 2'd0));

    generate
        if (CONSERVATIVE) begin : g_cons
            assert_no_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
                fwd_a_sel == 2'd0);
            assert_wb_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (rs_live && wb_wr && wb_rd == id_rs) |-> stall_fd);
        end else begin : g_fwd
            assert_mem_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (rs_live && mem_wr && mem_rd == id_rs && wb_wr && wb_rd == id_rs)
                |-> (fwd_a_sel == 2'd1));
        end
    endgenerate

endmodule

bind id_branch_unit idbr_chk #(
    .XLEN         (XLEN),
    .RW           (RW),
    .CONSERVATIVE (CONSERVATIVE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_branch (id_branch),
    .id_rs     (id_rs),
    .ex_rd     (ex_rd),
    .ex_wr     (ex_wr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_load  (mem_load),
    .wb_rd     (wb_rd),
    .wb_wr     (wb_wr),
    .br_taken  (br_taken),
    .br_target (br_target),
    .stall_fd  (stall_fd),
    .fwd_a_sel (fwd_a_sel),
    .fetch_pc  (fetch_pc)
);

// File: tb/id_branch_unit_tb.sv
module id_branch_unit_tb;

    localparam logic [31:0] RPC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br = 1'b0;
    logic [4:0]  rs = '0, rt = '0;
    logic [31:0] rs_v = '0, rt_v = '0, pc4 = '0;
    logic [15:0] imm = '0;
    logic [4:0]  x_rd = '0, m_rd = '0, w_rd = '0;
    logic        x_wr = 1'b0, x_ld = 1'b0, m_wr = 1'b0, m_ld = 1'b0, w_wr = 1'b0;
    logic [31:0] m_val = '0, w_val = '0;

    logic        b_tk, b_st, b_bub, c_tk, c_st, c_bub;
    logic [31:0] b_tg, b_pc, c_tg, c_pc;
    logic [1:0]  b_sa, b_sb, c_sa, c_sb;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] exp_pc [2];
    bit          obs_st [2];
    bit          obs_tk [2];

    always #2 clk = ~clk;

    id_branch_unit #(.CONSERVATIVE(1'b0), .RESET_PC(RPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_branch(br), .id_rs(rs), .id_rt(rt),
        .id_rs_val(rs_v), .id_rt_val(rt_v), .id_pc4(pc4), .id_imm(imm),
        .ex_rd(x_rd), .ex_wr(x_wr), .ex_load(x_ld),
        .mem_rd(m_rd), .mem_wr(m_wr), .mem_load(m_ld), .mem_val(m_val),
        .wb_rd(w_rd), .wb_wr(w_wr), .wb_val(w_val),
        .br_taken(b_tk), .br_target(b_tg), .stall_fd(b_st), .ex_bubble(b_bub),
        .fwd_a_sel(b_sa), .fwd_b_sel(b_sb), .fetch_pc(b_pc));

    id_branch_unit #(.CONSERVATIVE(1'b1), .RESET_PC(RPC)) u_dut_cons (
        .clk(clk), .rst_n(rst_n), .id_branch(br), .id_rs(rs), .id_rt(rt),
        .id_rs_val(rs_v), .id_rt_val(rt_v), .id_pc4(pc4), .id_imm(imm),
        .ex_rd(x_rd), .ex_wr(x_wr), .ex_load(x_ld),
        .mem_rd(m_rd), .mem_wr(m_wr), .mem_load(m_ld), .mem_val(m_val),
        .wb_rd(w_rd), .wb_wr(w_wr), .wb_val(w_val),
        .br_taken(c_tk), .br_target(c_tg), .stall_fd(c_st), .ex_bubble(c_bub),
        .fwd_a_sel(c_sa), .fwd_b_sel(c_sb), .fetch_pc(c_pc));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // behavioural model of one operand, written from the requirements
    task automatic ref_op(input bit cons, input logic [4:0] r, input logic [31:0] rfv,
                          output int sel, output bit hz, output logic [31:0] v);
        bit hx, hm, hw;
        sel = 0;
        hz  = 1'b0;
        hx  = x_wr && (x_rd == r);
        hm  = m_wr && (m_rd == r);
        hw  = w_wr && (w_rd == r);
        if (br && r != 5'd0) begin
            if (cons) begin
                hz = hx || hm || hw;
            end else begin
                hz = hx || (hm && m_ld);
                if (hm)      sel = 1;
                else if (hw) sel = 2;
            end
        end
        if (sel == 1)      v = m_val;
        else if (sel == 2) v = w_val;
        else               v = rfv;
    endtask

    task automatic ref_all(input bit cons, output bit st, output bit tk,
                           output int sa, output int sb, output logic [31:0] tg);
        bit ha, hb;
        logic [31:0] va, vb;
        ref_op(cons, rs, rs_v, sa, ha, va);
        ref_op(cons, rt, rt_v, sb, hb, vb);
        st = ha || hb;
        tk = br && !st && (va == vb);
        tg = pc4 + {{16{imm[15]}}, imm};
    endtask

    task automatic step();
        bit st, tk;
        int sa, sb;
        logic [31:0] tg;
        logic        a_st [2], a_bub [2], a_tk [2];
        logic [31:0] a_tg [2], a_pc [2];
        logic [1:0]  a_sa [2], a_sb [2];
        @(negedge clk);
        a_st[0] = b_st; a_bub[0] = b_bub; a_tk[0] = b_tk; a_tg[0] = b_tg;
        a_pc[0] = b_pc; a_sa[0] = b_sa;   a_sb[0] = b_sb;
        a_st[1] = c_st; a_bub[1] = c_bub; a_tk[1] = c_tk; a_tg[1] = c_tg;
        a_pc[1] = c_pc; a_sa[1] = c_sa;   a_sb[1] = c_sb;
        for (int m = 0; m < 2; m++) begin
            ref_all(m == 1, st, tk, sa, sb, tg);
            chk(m == 1 ? "R6" : "R5", "stall", a_st[m], st);
            chk("R8", "bubble", a_bub[m], st);
            chk("R1", "taken", a_tk[m], tk);
            chk("R2", "target", a_tg[m], tg);
            chk("R3", "sel_a", a_sa[m], sa);
            chk("R3", "sel_b", a_sb[m], sb);
            chk("R9", "fetch_pc", a_pc[m], exp_pc[m]);
            obs_st[m] = a_st[m];
            obs_tk[m] = a_tk[m];
            if (!st) exp_pc[m] = tk ? tg : exp_pc[m] + 32'd4;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic clear_stages();
        x_rd = '0; x_wr = 1'b0; x_ld = 1'b0;
        m_rd = '0; m_wr = 1'b0; m_ld = 1'b0; m_val = '0;
        w_rd = '0; w_wr = 1'b0; w_val = '0;
    endtask

    // one producer directly ahead of the branch, walked down the pipe
    task automatic run_dep(input int m, input bit ld, input bit dep,
                           input int want, input string req);
        int          nst;
        int          stage;
        bit          done;
        logic [31:0] pv, rf5;
        pv    = 32'h1234_0000 + 32'($urandom_range(0, 255));
        rf5   = pv ^ 32'h1;
        nst   = 0;
        stage = 0;
        done  = 1'b0;
        br = 1'b1; rs = dep ? 5'd5 : 5'd7; rt = 5'd6; rt_v = pv;
        pc4 = 32'h0000_2000; imm = 16'hFFF0;
        for (int k = 0; k < 8 && !done; k++) begin
            clear_stages();
            case (stage)
                0: begin x_rd = 5'd5; x_wr = 1'b1; x_ld = ld; end
                1: begin m_rd = 5'd5; m_wr = 1'b1; m_ld = ld;
                         m_val = ld ? 32'hDEAD_BEEF : pv; end
                2: begin w_rd = 5'd5; w_wr = 1'b1; w_val = pv; end
                default: rf5 = pv;
            endcase
            rs_v = dep ? rf5 : pv;
            step();
            if (!obs_st[m]) begin
                chk(req, "stall cycles", 32'(nst), 32'(want));
                chk(req, "taken after wait", 32'(obs_tk[m]), 32'd1);
                done = 1'b1;
            end else begin
                nst++;
                stage++;
            end
        end
        if (!done) chk(req, "resolved", 32'd0, 32'd1);
        br = 1'b0;
        clear_stages();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        exp_pc[0] = RPC;
        exp_pc[1] = RPC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset pc", b_pc, RPC);
        chk("R9", "reset pc cons", c_pc, RPC);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R4: ALU producer one cycle; R5: load two; independent zero
        run_dep(0, 1'b0, 1'b1, 1, "R4");
        run_dep(0, 1'b1, 1'b1, 2, "R5");
        run_dep(0, 1'b0, 1'b0, 0, "R4");
        // R6: wait through writeback
        run_dep(1, 1'b0, 1'b1, 3, "R6");
        run_dep(1, 1'b1, 1'b1, 3, "R6");
        run_dep(1, 1'b1, 1'b0, 0, "R6");

        // R7: register 0 claimed by execute
        clear_stages();
        br = 1'b1; rs = 5'd0; rt = 5'd0; rs_v = 32'h55; rt_v = 32'h55;
        x_rd = 5'd0; x_wr = 1'b1; m_rd = 5'd0; m_wr = 1'b1; m_ld = 1'b1;
        step();
        chk("R7", "r0 no stall", 32'(obs_st[0]), 32'd0);
        chk("R7", "r0 taken", 32'(obs_tk[0]), 32'd1);

        // R3: memory beats writeback
        clear_stages();
        br = 1'b1; rs = 5'd3; rt = 5'd4; rs_v = 32'h0; rt_v = 32'hABCD_0001;
        m_rd = 5'd3; m_wr = 1'b1; m_val = 32'hABCD_0001;
        w_rd = 5'd3; w_wr = 1'b1; w_val = 32'hABCD_0003;
        step();
        chk("R3", "memory value used", 32'(obs_tk[0]), 32'd1);

        // R1: unequal operands fall through
        clear_stages();
        br = 1'b1; rs = 5'd1; rt = 5'd2; rs_v = 32'h8000_0000; rt_v = 32'h0;
        imm = 16'h0040;
        step();
        chk("R1", "unequal not taken", 32'(obs_tk[0]), 32'd0);

        // R10: no branch in decode
        br = 1'b0; rs = 5'd2; x_rd = 5'd2; x_wr = 1'b1; x_ld = 1'b1;
        step();
        chk("R10", "idle no stall", 32'(obs_st[0]), 32'd0);
        chk("R10", "idle no stall cons", 32'(obs_st[1]), 32'd0);

        // random mix with a small register range
        for (int i = 0; i < 4000; i++) begin
            br    = ($urandom_range(0, 3) != 0);
            rs    = 5'($urandom_range(0, 3));
            rt    = 5'($urandom_range(0, 3));
            rs_v  = $urandom_range(0, 1) ? 32'h0000_00A5 : 32'hFFFF_FF5A;
            rt_v  = $urandom_range(0, 1) ? 32'h0000_00A5 : 32'hFFFF_FF5A;
            pc4   = $urandom;
            imm   = 16'($urandom);
            x_rd  = 5'($urandom_range(0, 3)); x_wr = 1'($urandom); x_ld = 1'($urandom);
            m_rd  = 5'($urandom_range(0, 3)); m_wr = 1'($urandom); m_ld = 1'($urandom);
            m_val = $urandom_range(0, 1) ? 32'h0000_00A5 : 32'h1;
            w_rd  = 5'($urandom_range(0, 3)); w_wr = 1'($urandom);
            w_val = $urandom_range(0, 1) ? 32'hFFFF_FF5A : 32'h2;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule